// File: doc/BRIEF.md
# Mode-Configurable Eight-Pin I/O Port

This block is an eight-pin I/O port mapped into a microcontroller's register space. It holds three registers: a pin direction register, an output data register and a pull-up enable register. For each pin it drives an output-enable, an output value and a pull-up enable toward the pads. The pad cells, the address generator and the standby controller are outside the block. The block only receives the address bits and the two standby levels from them.

A static two-bit mode input sets the role of the pins:

- **Address mode:** every pin drives a low-order address bit and the direction setting is locked.
- **Selectable-address mode:** pins with their direction bit set drive address bits. The other pins are inputs.
- **General mode:** pins with their direction bit set drive the data register. The other pins are inputs.

Hardware standby releases all pads and clears the direction setting. Software standby leaves the direction setting, and so the driven pins, as they are. The CPU side is a plain synchronous write and combinational read port with a 16-bit address.

Top module: `modecfg_port`

## Requirements
- R1: While `rst_n` is low, the direction, data and pull-up registers are all zero. After release, `pad_oe` is 8'hFF in mode 1 and 8'h00 in the other modes.
- R2: With `op_mode`=1 and `hw_stby` low, `pad_oe` is 8'hFF and `pad_out` equals `addr_lo`. Writes to the direction address (16'hFFB0) change nothing.
- R3: While `hw_stby` is high, `pad_oe` is 8'h00 in every mode.
- R4: With `op_mode`=2, `pad_oe` equals the direction register and `pad_out` equals `addr_lo`.
- R5: With `op_mode`=3 (the unused code 0 behaves the same), `pad_oe` equals the direction register and `pad_out` equals the data register.
- R6: A read of 16'hFFB0 returns 8'hFF in every mode.
- R7: A rising clock edge with `hw_stby` high clears the direction register. This clear wins over a write in the same cycle, and every register write is ignored while `hw_stby` is high.
- R8: While `sw_stby` is high, the direction register keeps its value, so driven pins stay driven.
- R9: A read of 16'hFFB2 returns the data register bit on pins whose effective direction is 1 and `pin_in` on the other pins. The effective direction is 8'hFF in mode 1 and the direction register otherwise.
- R10: `pad_pu` bit i is 1 only when pull-up bit i is 1, the effective direction bit i is 0 and the mode is not 1.
- R11: The data register (16'hFFB2) and pull-up register (16'hFFAC) read back the values written. Any other address, except 16'hFFB0, reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 2 | Static operating mode: 1, 2 or 3 |
| hw_stby | input | 1 | Hardware standby level |
| sw_stby | input | 1 | Software standby level |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_rdata | output | 8 | Combinational read data |
| addr_lo | input | 8 | Low address bits from the address generator |
| pin_in | input | 8 | Sampled pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
The sharpest collision is a CPU write to the direction address in the same cycle that hardware standby rises. The clear must win, so `pad_oe` must stay zero once standby drops. This case is forced with a directed step and also arises often under the random mix of writes and standby pulses. A second overlap is software standby together with direction writes. Retention is judged by `pad_oe` staying fixed across the standby window. Each cycle compares every output and the read data against a bench model kept from the requirements, with the pads modelled as tri-state lines with a weak pull-up.

// File: rtl/modecfg_port.sv
module modecfg_port #(
  parameter int          NPIN      = 8,
  parameter int          AW        = 16,
  parameter logic [15:0] DIR_ADR   = 16'hFFB0,
  parameter logic [15:0] DATA_ADR  = 16'hFFB2,
  parameter logic [15:0] PULL_ADR  = 16'hFFAC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      op_mode,
  input  logic            hw_stby,
  input  logic            sw_stby,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  input  logic            bus_we,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] addr_lo,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_pu
);
  localparam logic [NPIN-1:0] ONES = '1;

  logic [NPIN-1:0] dir_q, data_q, pull_q, dir_eff;
  logic            locked, addr_drv, wr_ok;

  assign locked   = (op_mode == 2'd1);
  assign addr_drv = (op_mode == 2'd1) || (op_mode == 2'd2);
  assign wr_ok    = bus_we && !hw_stby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
      pull_q <= '0;
    end else begin
      if (hw_stby)
        dir_q <= '0;
      else if (wr_ok && bus_addr == DIR_ADR[AW-1:0] && !locked)
        dir_q <= bus_wdata;
      if (wr_ok && bus_addr == DATA_ADR[AW-1:0]) data_q <= bus_wdata;
      if (wr_ok && bus_addr == PULL_ADR[AW-1:0]) pull_q <= bus_wdata;
    end
  end

  assign dir_eff = locked ? ONES : dir_q;
  assign pad_oe  = hw_stby ? '0 : dir_eff;
  assign pad_out = addr_drv ? addr_lo : data_q;
  assign pad_pu  = locked ? '0 : (pull_q & ~dir_eff);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == DIR_ADR[AW-1:0])       bus_rdata = ONES;
    else if (bus_addr == DATA_ADR[AW-1:0]) bus_rdata = (data_q & dir_eff) | (pin_in & ~dir_eff);
    else if (bus_addr == PULL_ADR[AW-1:0]) bus_rdata = pull_q;
  end

  // R3
  stby_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |-> pad_oe == '0);

  // R2
  addr_mode_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !hw_stby) |-> (pad_oe == ONES && pad_out == addr_lo));

  // R10
  pull_vs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  // R7
  stby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_stby && !locked) |=> (hw_stby || pad_oe == '0));

  // R8
  sw_retain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby && !(bus_we && bus_addr == DIR_ADR[AW-1:0]))
      |=> (hw_stby || $stable(pad_oe)));

  // R6
  dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == DIR_ADR[AW-1:0]) |-> bus_rdata == ONES);
endmodule

// File: tb/modecfg_port_tb.sv
module modecfg_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_DIR = 16'hFFB0, A_DATA = 16'hFFB2, A_PULL = 16'hFFAC;

  logic clk = 0, rst_n = 0, hw_stby = 0, sw_stby = 0, bus_we = 0;
  logic [1:0]  op_mode = 2'd3;
  logic [15:0] bus_addr = 0;
  logic [7:0]  bus_wdata = 0, addr_lo = 0, ext_en = 0, ext_val = 0;
  logic [7:0]  bus_rdata, pad_oe, pad_out, pad_pu, pin_in;
  logic [7:0]  m_dir, m_data, m_pull;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // pad: driven by block, else external driver, else weak pull-up
  for (genvar i = 0; i < 8; i++) begin : g_pad
    assign pin_in[i] = pad_oe[i] ? pad_out[i] : (ext_en[i] ? ext_val[i] : 1'b1);
  end

  modecfg_port dut_i (.clk, .rst_n, .op_mode, .hw_stby, .sw_stby, .bus_addr,
    .bus_wdata, .bus_we, .bus_rdata, .addr_lo, .pin_in, .pad_oe, .pad_out, .pad_pu);

  function automatic logic [7:0] eff_dir();
    return (op_mode == 2'd1) ? 8'hFF : m_dir;
  endfunction
  function automatic logic [7:0] exp_oe();
    return hw_stby ? 8'h00 : eff_dir();
  endfunction
  function automatic logic [7:0] exp_out();
    return (op_mode == 2'd1 || op_mode == 2'd2) ? addr_lo : m_data;
  endfunction
  function automatic logic [7:0] exp_pu();
    return (op_mode == 2'd1) ? 8'h00 : (m_pull & ~eff_dir());
  endfunction
  function automatic logic [7:0] exp_rd();
    logic [7:0] oe, pins;
    oe = exp_oe();
    pins = (oe & exp_out()) | (~oe & ((ext_en & ext_val) | ~ext_en));
    if (bus_addr == A_DIR)  return 8'hFF;
    if (bus_addr == A_DATA) return (m_data & eff_dir()) | (pins & ~eff_dir());
    if (bus_addr == A_PULL) return m_pull;
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s mode=%0d actual=%h expected=%h", tag, op_mode, act, exp);
    end
  endtask

  function automatic string mode_tag();
    return (op_mode == 2'd1) ? "R2" : (op_mode == 2'd2) ? "R4" : "R5";
  endfunction

  task automatic check_all();
    chk(hw_stby ? "R3" : mode_tag(), pad_oe, exp_oe());
    chk(mode_tag(), pad_out, exp_out());
    chk("R10", pad_pu, exp_pu());
    chk(bus_addr == A_DIR ? "R6" : bus_addr == A_DATA ? "R9" : "R11", bus_rdata, exp_rd());
  endtask

  task automatic step(input logic we, input logic [15:0] a, input logic [7:0] wd,
                      input logic hw, input logic sw);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = wd; hw_stby = hw; sw_stby = sw;
    #1 check_all();
    @(posedge clk);
    if (hw) m_dir = 8'h00;
    else if (we) begin
      if (a == A_DIR && op_mode != 2'd1) m_dir = wd;
      if (a == A_DATA) m_data = wd;
      if (a == A_PULL) m_pull = wd;
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 0; op_mode = m; bus_we = 0; hw_stby = 0; sw_stby = 0;
    m_dir = 0; m_data = 0; m_pull = 0;
    #1;
    chk("R1", pad_pu, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1 chk("R1", pad_oe, (m == 2'd1) ? 8'hFF : 8'h00);
    bus_addr = A_DATA; #1 chk("R1", pad_out & 8'h00, 8'h00);
    bus_addr = A_PULL; #1 chk("R1", bus_rdata, 8'h00);
  endtask

  function automatic logic [15:0] rnd_addr();
    case ($urandom_range(0, 4))
      0: return A_DIR;
      1: return A_DATA;
      2: return A_PULL;
      3: return A_DIR + 16'd1;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m));
      // directed: write direction then collide with hardware standby (R7)
      step(1, A_DIR, 8'hA5, 0, 0);
      step(1, A_DATA, 8'h3C, 0, 0);
      step(1, A_PULL, 8'hF0, 0, 0);
      step(1, A_DIR, 8'h5A, 1, 0);
      step(0, A_DATA, 8'h00, 0, 0);
      if (m != 1) chk("R7", pad_oe, 8'h00);
      step(1, A_DATA, 8'hFF, 1, 0);
      step(0, A_DATA, 8'h00, 0, 0);
      chk("R7", bus_rdata & eff_dir(), m_data & eff_dir());
      // directed: software standby retention (R8)
      step(1, A_DIR, 8'hC3, 0, 0);
      for (int k = 0; k < 4; k++) step(0, A_PULL, 8'h00, 0, 1);
      chk("R8", pad_oe, (m == 1) ? 8'hFF : 8'hC3);
      // random mix
      for (int n = 0; n < 600; n++) begin
        addr_lo = 8'($urandom); ext_en = 8'($urandom); ext_val = 8'($urandom);
        step($urandom_range(0, 1) == 1, rnd_addr(), 8'($urandom),
             $urandom_range(0, 9) == 0, $urandom_range(0, 4) == 0);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule